// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address after a TLB miss by reading a page table that lives in memory. A requester gives it the frame number of the outer table page, the virtual address and a one-cycle start strobe. The walker then makes two dependent reads through a simple read port that allows one read in flight. The first read picks an entry in the outer table and yields the frame of an inner table page. The second read picks an entry in that inner page and yields the frame of the target page.

A walk ends with a one-cycle done pulse and a physical address, or with a one-cycle fault pulse when the valid bit is clear in the entry read at either level. Memory latency is arbitrary: the walker waits in a read state until read data is marked valid. The physical address output keeps its value until the next walk is accepted. The walker is meant to sit beside a TLB, and the TLB's refill logic uses the result.

Top module: `pgw_walker`

## Requirements
- R1: After reset `mem_req_o`, `done_o` and `fault_o` are low and `pa_o` is zero.
- R2: A start in the idle state raises `mem_req_o` for exactly one cycle, in the cycle after the start is sampled. The address is `root_frame_i * 4096 + va[31:22] * 4`.
- R3: A page table entry holds its frame number in bits 31:12 and its valid bit in bit 0. A valid outer entry causes a second one-cycle request in the cycle after its read data is accepted, at address `outer_frame * 4096 + va[21:12] * 4`.
- R4: A valid inner entry makes `pa_o` equal to `{inner_frame, va[11:0]}`. `done_o` is high for exactly one cycle, in the cycle after the inner read data is accepted.
- R5: An outer entry with bit 0 clear gives a one-cycle `fault_o` pulse, one cycle after its data, and no second request is issued.
- R6: An inner entry with bit 0 clear gives a one-cycle `fault_o` pulse and leaves `pa_o` at zero.
- R7: Entry bits 11:1 have no effect on either the addresses produced or the physical address.
- R8: A start that arrives while a walk is in progress is ignored. The walk's requests and result belong only to the address accepted first.
- R9: `pa_o` is cleared when a walk is accepted and then holds its value until the next accepted start.
- R10: `mem_rvalid_i` outside a wait for read data is ignored. It causes no request, no pulse and no change to `pa_o`.
- R11: At most one read is outstanding. `mem_addr_o` stays stable while the walker waits for its data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Walk request strobe |
| root_frame_i | input | 20 | Frame number of the outer table page |
| va_i | input | 32 | Virtual address to translate |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rdata_i | input | 32 | Entry read from memory |
| mem_rvalid_i | input | 1 | Read data valid |
| done_o | output | 1 | Translation finished pulse |
| fault_o | output | 1 | Page fault pulse |
| pa_o | output | 32 | Physical address result |

## Verification
The hardest situations to reach from the ports are a new start strobe that lands while the walker waits for read data, and read-valid arriving when no read is outstanding. The bench's memory responder has a latency set per test. One test stretches it to four cycles and pulses a start with a different address in the middle of the walk, then checks the request log and the result against the first address only. Another test has the responder raise read-valid with a valid-looking entry while the walker is idle, and confirms that no request, pulse or address change follows.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_ISSUE = 2'd1,
      S_WAIT  = 2'd2,
      S_FIN   = 2'd3
   } walk_state_t;

endpackage

// File: rtl/pgw_va_slicer.sv
module pgw_va_slicer #(
   parameter int VA_W   = 32,
   parameter int IDX_W  = 10,
   parameter int OFF_W  = 12,
   parameter int LEVELS = 2
) (
   input  logic [VA_W-1:0]                va_i,
   output logic [LEVELS-1:0][IDX_W-1:0]   idx_o,
   output logic [OFF_W-1:0]               off_o
);

   initial begin
      assert_split_fits_R3: assert (LEVELS * IDX_W + OFF_W == VA_W)
         else $fatal(1, "index fields and offset must cover the address");
   end

   // level 0 takes the most significant index field
   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      assign idx_o[g] = va_i[VA_W-1-g*IDX_W -: IDX_W];
   end

   assign off_o = va_i[OFF_W-1:0];

endmodule

// File: rtl/pgw_pte_decode.sv
module pgw_pte_decode #(
   parameter int PTE_W     = 32,
   parameter int FRAME_W   = 20,
   parameter int VALID_POS = 0
) (
   input  logic [PTE_W-1:0]   pte_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic               valid_o
);

   initial begin
      assert_valid_below_frame_R7: assert (VALID_POS < PTE_W - FRAME_W)
         else $fatal(1, "valid bit overlaps the frame field");
   end

   logic unused_pte_bits;

   assign frame_o         = pte_i[PTE_W-1 -: FRAME_W];
   assign valid_o         = pte_i[VALID_POS];
   assign unused_pte_bits = ^pte_i;

endmodule

// File: rtl/pgw_walk_ctrl.sv
module pgw_walk_ctrl
   import pgw_pkg::*;
#(
   parameter int LEVELS = 2,
   localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             rvalid_i,
   input  logic             pte_valid_i,
   output walk_state_t      state_o,
   output logic [LVL_W-1:0] lvl_o,
   output logic             last_o,
   output logic             flt_o
);

   walk_state_t      state_q, state_d;
   logic [LVL_W-1:0] lvl_q, lvl_d;
   logic             flt_q, flt_d;

   assign last_o = (lvl_q == LVL_W'(LEVELS - 1));

   always_comb begin
      state_d = state_q;
      lvl_d   = lvl_q;
      flt_d   = flt_q;
      unique case (state_q)
         S_IDLE: begin
            if (start_i) begin
               state_d = S_ISSUE;
               lvl_d   = '0;
               flt_d   = 1'b0;
            end
         end
         S_ISSUE: state_d = S_WAIT;
         S_WAIT: begin
            if (rvalid_i) begin
               if (!pte_valid_i) begin
                  state_d = S_FIN;
                  flt_d   = 1'b1;
               end else if (last_o) begin
                  state_d = S_FIN;
               end else begin
                  state_d = S_ISSUE;
                  lvl_d   = lvl_q + 1'b1;
               end
            end
         end
         S_FIN:   state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         lvl_q   <= '0;
         flt_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         lvl_q   <= lvl_d;
         flt_q   <= flt_d;
      end
   end

   assign state_o = state_q;
   assign lvl_o   = lvl_q;
   assign flt_o   = flt_q;

   // R11: a wait without data neither moves on nor changes level
   assert_wait_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WAIT && !rvalid_i) |=> (state_q == S_WAIT && $stable(lvl_q)));

   // R8: a start while busy does not restart the walk at level 0
   assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WAIT && start_i && !rvalid_i) |=> state_q == S_WAIT);

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
   import pgw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int IDX_W     = 10,
   parameter int OFF_W     = 12,
   parameter int LEVELS    = 2,
   parameter int PTE_W     = 32,
   parameter int FRAME_W   = 20,
   parameter int VALID_POS = 0,
   localparam int PA_W      = FRAME_W + OFF_W,
   localparam int ENT_SHIFT = $clog2(PTE_W / 8),
   localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [FRAME_W-1:0] root_frame_i,
   input  logic [VA_W-1:0]    va_i,
   output logic               mem_req_o,
   output logic [PA_W-1:0]    mem_addr_o,
   input  logic [PTE_W-1:0]   mem_rdata_i,
   input  logic               mem_rvalid_i,
   output logic               done_o,
   output logic               fault_o,
   output logic [PA_W-1:0]    pa_o
);

   initial begin
      assert_entry_in_page_R2: assert (IDX_W + ENT_SHIFT <= OFF_W)
         else $fatal(1, "a table page cannot hold all indexed entries");
      assert_entry_bytes_R2: assert (PTE_W % 8 == 0 && PTE_W >= FRAME_W + 1)
         else $fatal(1, "entry width unsupported");
   end

   walk_state_t                  state;
   logic [LVL_W-1:0]             lvl;
   logic                         last_lvl;
   logic                         flt;
   logic [VA_W-1:0]              va_q;
   logic [FRAME_W-1:0]           tbl_q;
   logic [PA_W-1:0]              pa_q;
   logic [LEVELS-1:0][IDX_W-1:0] idx;
   logic [OFF_W-1:0]             off;
   logic [FRAME_W-1:0]           pte_frame;
   logic                         pte_valid;
   logic                         walk_go;
   logic                         capture;
   logic [IDX_W-1:0]             cur_idx;

   pgw_walk_ctrl #(.LEVELS(LEVELS)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .rvalid_i    (mem_rvalid_i),
      .pte_valid_i (pte_valid),
      .state_o     (state),
      .lvl_o       (lvl),
      .last_o      (last_lvl),
      .flt_o       (flt)
   );

   pgw_va_slicer #(
      .VA_W   (VA_W),
      .IDX_W  (IDX_W),
      .OFF_W  (OFF_W),
      .LEVELS (LEVELS)
   ) u_slice (
      .va_i  (va_q),
      .idx_o (idx),
      .off_o (off)
   );

   pgw_pte_decode #(
      .PTE_W     (PTE_W),
      .FRAME_W   (FRAME_W),
      .VALID_POS (VALID_POS)
   ) u_pte (
      .pte_i   (mem_rdata_i),
      .frame_o (pte_frame),
      .valid_o (pte_valid)
   );

   assign walk_go = (state == S_IDLE) && start_i;
   assign capture = (state == S_WAIT) && mem_rvalid_i;
   assign cur_idx = idx[lvl];

   // entry address: table frame, index scaled by entry size, zero fill
   if (IDX_W + ENT_SHIFT == OFF_W) begin : g_addr_tight
      if (ENT_SHIFT > 0) begin : g_pad
         assign mem_addr_o = {tbl_q, cur_idx, {ENT_SHIFT{1'b0}}};
      end else begin : g_nopad
         assign mem_addr_o = {tbl_q, cur_idx};
      end
   end else begin : g_addr_loose
      assign mem_addr_o = {tbl_q, {OFF_W{1'b0}}}
                        | (PA_W'(cur_idx) << ENT_SHIFT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q  <= '0;
         tbl_q <= '0;
         pa_q  <= '0;
      end else if (walk_go) begin
         va_q  <= va_i;
         tbl_q <= root_frame_i;
         pa_q  <= '0;
      end else if (capture && pte_valid) begin
         if (last_lvl) pa_q  <= {pte_frame, off};
         else          tbl_q <= pte_frame;
      end
   end

   assign mem_req_o = (state == S_ISSUE);
   assign done_o    = (state == S_FIN) && !flt;
   assign fault_o   = (state == S_FIN) && flt;
   assign pa_o      = pa_q;

   assert_req_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o);

   assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> $stable(mem_addr_o));

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_fault_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |=> !fault_o);

   assert_outcome_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fault_o));

   assert_no_req_after_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> !mem_req_o);

   assert_pa_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!walk_go && !(capture && pte_valid && last_lvl)) |=> $stable(pa_o));

endmodule

// File: tb/tb_pgw_walker.sv
module tb_pgw_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [19:0] root_frame_i = '0;
   logic [31:0] va_i = '0;
   logic        mem_req_o;
   logic [31:0] mem_addr_o;
   logic [31:0] mem_rdata_i = '0;
   logic        mem_rvalid_i = 1'b0;
   logic        done_o, fault_o;
   logic [31:0] pa_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int lat = 1;
   bit stray = 1'b0;
   logic [31:0] stray_data = '0;

   logic [31:0] pt [int unsigned];
   logic [31:0] req_addr [8];
   int          req_cyc [8];
   int          req_n = 0;
   int          rv_cyc = 0;

   localparam logic [19:0] ROOT = 20'h00010;

   pgw_walker dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .root_frame_i (root_frame_i),
      .va_i         (va_i),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .mem_rdata_i  (mem_rdata_i),
      .mem_rvalid_i (mem_rvalid_i),
      .done_o       (done_o),
      .fault_o      (fault_o),
      .pa_o         (pa_o)
   );

   always #2 clk = ~clk;

   initial forever begin
      @(posedge clk);
      cyc = cyc + 1;
   end

   // memory model: answers each request after lat cycles
   initial forever begin
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      if (stray) begin
         mem_rdata_i  = stray_data;
         mem_rvalid_i = 1'b1;
         stray        = 1'b0;
      end else if (mem_req_o) begin
         logic [31:0] a;
         a = mem_addr_o;
         if (req_n < 8) begin
            req_addr[req_n] = a;
            req_cyc[req_n]  = cyc;
         end
         req_n = req_n + 1;
         repeat (lat) @(negedge clk);
         mem_rdata_i  = pt.exists(a) ? pt[a] : 32'h0;
         mem_rvalid_i = 1'b1;
         rv_cyc       = cyc;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ent_addr(input logic [19:0] fr, input logic [9:0] ix);
      return {fr, 12'h000} + {20'h0, ix, 2'b00};
   endfunction

   // launches a walk and waits for its end; returns pulse kind and cycle
   task automatic walk(input logic [31:0] va, output bit is_done, output bit is_fault,
                       output int end_cyc, output int start_cyc);
      int n;
      req_n = 0;
      @(negedge clk);
      va_i = va;
      root_frame_i = ROOT;
      start_i = 1'b1;
      start_cyc = cyc;
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      is_done = 1'b0;
      is_fault = 1'b0;
      end_cyc = 0;
      while (!done_o && !fault_o && n < 100) begin
         @(negedge clk);
         n = n + 1;
      end
      is_done  = done_o;
      is_fault = fault_o;
      end_cyc  = cyc;
      @(negedge clk);
      check(!done_o && !fault_o, "R4/R5 pulse width", {30'h0, done_o, fault_o}, 32'h0);
   endtask

   task automatic t_reset();
      check(mem_req_o == 1'b0, "R1 req", {31'h0, mem_req_o}, 32'h0);
      check(done_o == 1'b0 && fault_o == 1'b0, "R1 pulses", {30'h0, done_o, fault_o}, 32'h0);
      check(pa_o == 32'h0, "R1 pa", pa_o, 32'h0);
   endtask

   task automatic t_success();
      bit d, f;
      int e, s;
      lat = 1;
      walk({10'h005, 10'h123, 12'hABC}, d, f, e, s);
      check(d && !f, "R4 done", {30'h0, d, f}, 32'h2);
      check(req_n == 2, "R3 request count", req_n, 2);
      check(req_addr[0] == ent_addr(ROOT, 10'h005), "R2 outer addr", req_addr[0],
            ent_addr(ROOT, 10'h005));
      check(req_cyc[0] == s + 1, "R2 outer timing", req_cyc[0], s + 1);
      check(req_addr[1] == ent_addr(20'h00020, 10'h123), "R3 inner addr", req_addr[1],
            ent_addr(20'h00020, 10'h123));
      check(req_cyc[1] == req_cyc[0] + lat + 1, "R3 inner timing", req_cyc[1],
            req_cyc[0] + lat + 1);
      check(e == rv_cyc + 1, "R4 done timing", e, rv_cyc + 1);
      check(pa_o == 32'h54321ABC, "R4 pa", pa_o, 32'h54321ABC);
      repeat (5) @(negedge clk);
      check(pa_o == 32'h54321ABC, "R9 pa holds", pa_o, 32'h54321ABC);
   endtask

   task automatic t_junk_bits();
      bit d, f;
      int e, s;
      lat = 3;
      walk({10'h3FF, 10'h3FF, 12'hFFF}, d, f, e, s);
      check(d && !f, "R7 done with junk bits", {30'h0, d, f}, 32'h2);
      check(req_addr[1] == ent_addr(20'h00030, 10'h3FF), "R7 inner addr", req_addr[1],
            ent_addr(20'h00030, 10'h3FF));
      check(e == rv_cyc + 1, "R4 done timing slow memory", e, rv_cyc + 1);
      check(pa_o == 32'hFEDCBFFF, "R7 pa", pa_o, 32'hFEDCBFFF);
   endtask

   task automatic t_stray();
      int pulses = 0;
      int reqs = 0;
      @(posedge clk);
      #1;
      stray_data = {20'h11111, 12'h001};
      stray = 1'b1;
      repeat (6) begin
         @(negedge clk);
         if (done_o || fault_o) pulses++;
         if (mem_req_o) reqs++;
      end
      check(pulses == 0 && reqs == 0, "R10 stray data", pulses + reqs, 0);
      check(pa_o == 32'hFEDCBFFF, "R10 pa unchanged", pa_o, 32'hFEDCBFFF);
   endtask

   task automatic t_outer_fault();
      bit d, f;
      int e, s;
      lat = 2;
      walk({10'h001, 10'h055, 12'h777}, d, f, e, s);
      check(f && !d, "R5 fault", {30'h0, d, f}, 32'h1);
      check(e == rv_cyc + 1, "R5 fault timing", e, rv_cyc + 1);
      repeat (4) @(negedge clk);
      check(req_n == 1, "R5 no second request", req_n, 1);
      check(pa_o == 32'h0, "R9 cleared at start", pa_o, 32'h0);
   endtask

   task automatic t_inner_fault();
      bit d, f;
      int e, s;
      lat = 1;
      walk({10'h002, 10'h010, 12'h123}, d, f, e, s);
      check(f && !d, "R6 fault", {30'h0, d, f}, 32'h1);
      check(req_n == 2, "R6 two requests", req_n, 2);
      check(req_addr[1] == ent_addr(20'h00050, 10'h010), "R6 inner addr", req_addr[1],
            ent_addr(20'h00050, 10'h010));
      check(pa_o == 32'h0, "R6 pa zero", pa_o, 32'h0);
   endtask

   task automatic t_busy_start();
      int n = 0;
      lat = 4;
      req_n = 0;
      @(negedge clk);
      va_i = {10'h005, 10'h123, 12'h00F};
      root_frame_i = ROOT;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (2) @(negedge clk);
      va_i = {10'h3FF, 10'h3FF, 12'hFFF};
      root_frame_i = 20'h00099;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (!done_o && !fault_o && n < 100) begin
         @(negedge clk);
         n++;
      end
      check(done_o == 1'b1, "R8 first walk completes", {31'h0, done_o}, 32'h1);
      check(pa_o == 32'h5432100F, "R8 result of first address", pa_o, 32'h5432100F);
      repeat (10) @(negedge clk);
      check(req_n == 2, "R8 no extra walk", req_n, 2);
      check(req_addr[0] == ent_addr(ROOT, 10'h005) &&
            req_addr[1] == ent_addr(20'h00020, 10'h123), "R8 addresses", req_addr[1],
            ent_addr(20'h00020, 10'h123));
   endtask

   initial begin
      pt[ent_addr(ROOT, 10'h005)]          = {20'h00020, 12'h001};
      pt[ent_addr(20'h00020, 10'h123)]     = {20'h54321, 12'h001};
      pt[ent_addr(ROOT, 10'h3FF)]          = {20'h00030, 12'hFFF};
      pt[ent_addr(20'h00030, 10'h3FF)]     = {20'hFEDCB, 12'h7FF};
      pt[ent_addr(ROOT, 10'h001)]          = {20'h00040, 12'hFFE};
      pt[ent_addr(20'h00040, 10'h055)]     = {20'h0ABCD, 12'h001};
      pt[ent_addr(ROOT, 10'h002)]          = {20'h00050, 12'h001};
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_success();
      t_junk_bits();
      t_stray();
      t_outer_fault();
      t_inner_fault();
      t_busy_start();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule